// File: doc/BRIEF.md
# External Bus Mastership Controller

This block decides when a processor core may drive a shared external bus. It raises an active-low request toward an outside arbiter whenever the core has an external access pending, or whenever software sets a hold bit. It takes ownership only after the arbiter's active-low grant is present and the shared active-low busy line has gone free. The core learns through `bus_owned` when it may start bus cycles. It reports the end of each bus cycle with `cycle_done`.

Ownership is parked. When the core stops requesting, the block stays master for as long as the grant is present, so a later access starts without a new arbitration round. When the grant is withdrawn during an access, the block keeps the bus until the bus cycle in flight ends. This applies even when the core still needs further cycles for the same operation. While master, the block pulls the busy line low. It lets the line go high on the clock after it gives up the bus.

All inputs are sampled on the rising edge of the bus clock. Reset is synchronous and active high.

Top module: `xbm_ctrl`

## Requirements
- R1: On the first rising edge with `rst` high, `bus_req_n` becomes 1, `bus_owned` becomes 0 and `bus_busy_out_n` becomes 1. The block returns to the slave state, including when it was master.
- R2: One clock after any bit of `core_ext_req` is sampled 1, `bus_req_n` is 0. One clock after all bits are 0 and `req_hold` is 0, `bus_req_n` is 1. This holds whether or not the block owns the bus.
- R3: With `req_hold` at 1, `bus_req_n` is 0 one clock later even when no bit of `core_ext_req` is set.
- R4: A slave that samples `bus_grant_n` = 0 enters a waiting state and is not yet owner. In the waiting state, an edge that samples `bus_grant_n` = 0 and `bus_busy_in_n` = 1 sets `bus_owned` to 1 after that edge.
- R5: While waiting, each edge that samples `bus_busy_in_n` = 0 leaves `bus_owned` at 0.
- R6: While waiting, an edge that samples `bus_grant_n` = 1 returns the block to slave, with `bus_owned` at 0.
- R7: When the owner has no request and keeps seeing the grant, it stays owner (parked), with `bus_req_n` at 1.
- R8: A parked owner that samples `bus_grant_n` = 1 clears `bus_owned` after that edge.
- R9: An owner in an active bus cycle that samples `bus_grant_n` = 1 keeps `bus_owned` at 1 for each edge where `cycle_done` is 0.
- R10: An active owner releases the bus after the edge that samples `cycle_done` = 1 with `bus_grant_n` = 1. This happens even if `core_ext_req` is still set, and `bus_req_n` then stays 0.
- R11: A parked owner whose core raises a request while the grant is present continues as owner, with `bus_owned` held at 1 and no arbitration.
- R12: `bus_busy_out_n` is 0 exactly when `bus_owned` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| core_ext_req | input | N_REQ | Core external-access needs, one bit per source |
| req_hold | input | 1 | Software bit forcing the request active |
| bus_grant_n | input | 1 | Active-low grant from the external arbiter |
| bus_busy_in_n | input | 1 | Sampled state of the shared active-low busy line |
| cycle_done | input | 1 | Core pulse marking the last clock of a bus cycle |
| bus_req_n | output | 1 | Active-low bus request, always driven |
| bus_owned | output | 1 | High while the core may use the external bus |
| bus_busy_out_n | output | 1 | Busy drive: 0 pulls the line low, 1 releases it |

## Verification
The assertions check on every cycle the following behaviours:
- the request output follows the core needs and the hold bit one clock later;
- a waiting block never becomes owner while the busy line is low;
- an active owner never lets go between `cycle_done` pulses;
- parked ownership persists while the grant stays;
- the busy drive mirrors ownership.

Only the bench's scenarios show the complete sequences: request, grant, wait for busy, own, park, resume, and release mid-operation. They also show that reset during ownership returns everything to idle, and the exact clock at which `bus_owned` changes in each path.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  typedef enum logic [1:0] {
    ST_SLAVE         = 2'd0,
    ST_WAIT_BUSY     = 2'd1,
    ST_MASTER_ACTIVE = 2'd2,
    ST_MASTER_PARKED = 2'd3
  } xbm_state_e;

  function automatic logic is_owner(xbm_state_e s);
    return (s == ST_MASTER_ACTIVE) || (s == ST_MASTER_PARKED);
  endfunction
endpackage

// File: rtl/xbm_req_gen.sv
module xbm_req_gen #(
  parameter int N_REQ = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] core_ext_req,
  input  logic             req_hold,
  output logic             any_req,
  output logic             bus_req_n
);
  // OR-reduce the request sources through a generate chain
  logic [N_REQ:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_REQ; i++) begin : g_or
    assign chain[i+1] = chain[i] | core_ext_req[i];
  end
  assign any_req = chain[N_REQ];

  always_ff @(posedge clk) begin
    if (rst) bus_req_n <= 1'b1;
    else     bus_req_n <= ~(any_req | req_hold);
  end

  assert_hold_forces_req_R3: assert property (@(posedge clk) disable iff (rst)
    req_hold |=> !bus_req_n);
endmodule

// File: rtl/xbm_arb_fsm.sv
module xbm_arb_fsm
  import xbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       any_req,
  input  logic       bus_grant_n,
  input  logic       bus_busy_in_n,
  input  logic       cycle_done,
  output xbm_state_e state,
  output xbm_state_e state_nxt
);
  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_SLAVE:
        if (!bus_grant_n) state_nxt = ST_WAIT_BUSY;
      ST_WAIT_BUSY:
        if (bus_grant_n)        state_nxt = ST_SLAVE;
        else if (bus_busy_in_n) state_nxt = any_req ? ST_MASTER_ACTIVE : ST_MASTER_PARKED;
      ST_MASTER_ACTIVE:
        if (cycle_done) begin
          if (bus_grant_n)  state_nxt = ST_SLAVE;
          else if (any_req) state_nxt = ST_MASTER_ACTIVE;
          else              state_nxt = ST_MASTER_PARKED;
        end
      ST_MASTER_PARKED:
        if (bus_grant_n)  state_nxt = ST_SLAVE;
        else if (any_req) state_nxt = ST_MASTER_ACTIVE;
      default: state_nxt = ST_SLAVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SLAVE;
    else     state <= state_nxt;
  end

  assert_slave_never_owns_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLAVE) |=> !is_owner(state));
  assert_wait_on_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_BUSY && !bus_busy_in_n) |=> !is_owner(state));
  assert_park_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MASTER_PARKED && !bus_grant_n && !any_req) |=> (state == ST_MASTER_PARKED));
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (is_owner(state) && bus_grant_n && (state == ST_MASTER_PARKED || cycle_done))
      |=> (state == ST_SLAVE));
  assert_cycle_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MASTER_ACTIVE && !cycle_done) |=> (state == ST_MASTER_ACTIVE));
  assert_resume_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MASTER_PARKED && !bus_grant_n && any_req) |=> (state == ST_MASTER_ACTIVE));
endmodule

// File: rtl/xbm_busy_drv.sv
module xbm_busy_drv
  import xbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  xbm_state_e state_nxt,
  output logic       bus_owned,
  output logic       bus_busy_out_n
);
  // Separate flops so both outputs leave the block registered
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_owned      <= 1'b0;
      bus_busy_out_n <= 1'b1;
    end else begin
      bus_owned      <= is_owner(state_nxt);
      bus_busy_out_n <= ~is_owner(state_nxt);
    end
  end
endmodule

// File: rtl/xbm_ctrl.sv
module xbm_ctrl
  import xbm_pkg::*;
#(
  parameter int N_REQ = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] core_ext_req,
  input  logic             req_hold,
  input  logic             bus_grant_n,
  input  logic             bus_busy_in_n,
  input  logic             cycle_done,
  output logic             bus_req_n,
  output logic             bus_owned,
  output logic             bus_busy_out_n
);
  logic       any_req;
  xbm_state_e state;
  xbm_state_e state_nxt;

  xbm_req_gen #(.N_REQ(N_REQ)) u_req (
    .clk(clk), .rst(rst), .core_ext_req(core_ext_req), .req_hold(req_hold),
    .any_req(any_req), .bus_req_n(bus_req_n)
  );

  xbm_arb_fsm u_fsm (
    .clk(clk), .rst(rst), .any_req(any_req), .bus_grant_n(bus_grant_n),
    .bus_busy_in_n(bus_busy_in_n), .cycle_done(cycle_done),
    .state(state), .state_nxt(state_nxt)
  );

  xbm_busy_drv u_busy (
    .clk(clk), .rst(rst), .state_nxt(state_nxt),
    .bus_owned(bus_owned), .bus_busy_out_n(bus_busy_out_n)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (bus_req_n && !bus_owned && bus_busy_out_n));
  assert_req_follows_need_R2: assert property (@(posedge clk) disable iff (rst)
    (|core_ext_req) |=> !bus_req_n);
  assert_req_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (!(|core_ext_req) && !req_hold) |=> bus_req_n);
  assert_owned_matches_state_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_owned == is_owner(state)));
  assert_busy_mirrors_owner_R12: assert property (@(posedge clk) disable iff (rst)
    bus_owned |-> !bus_busy_out_n);
  assert_busy_free_when_slave_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_owned |-> bus_busy_out_n);
endmodule

// File: tb/tb_xbm_ctrl.sv
`timescale 1ns/1ps
module tb_xbm_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] core_ext_req = '0;
  logic       req_hold = 1'b0;
  logic       bus_grant_n = 1'b1;
  logic       bus_busy_in_n = 1'b1;
  logic       cycle_done = 1'b0;
  logic       bus_req_n, bus_owned, bus_busy_out_n;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  xbm_ctrl #(.N_REQ(2)) dut (
    .clk(clk), .rst(rst), .core_ext_req(core_ext_req), .req_hold(req_hold),
    .bus_grant_n(bus_grant_n), .bus_busy_in_n(bus_busy_in_n), .cycle_done(cycle_done),
    .bus_req_n(bus_req_n), .bus_owned(bus_owned), .bus_busy_out_n(bus_busy_out_n)
  );

  // Row: tag[13:10] ext[9:8] hold[7] grant_n[6] busy_n[5] done[4] pad[3] exp req_n[2] owned[1] busy_out_n[0]
  localparam int NV = 23;
  localparam logic [13:0] VEC [NV] = '{
    {4'd1,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b101}, // R1 idle after reset
    {4'd2,  2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b001}, // R2 request as slave
    {4'd4,  2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001}, // R4 grant -> wait
    {4'd5,  2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001}, // R5 busy low keeps waiting
    {4'd4,  2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b010}, // R4 busy free -> owner
    {4'd12, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010}, // R12 active owner drives busy
    {4'd7,  2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b110}, // R7 done, no need -> parked
    {4'd7,  2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b110}, // R7 parked stays
    {4'd11, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010}, // R11 resume from park
    {4'd9,  2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010}, // R9 grant lost mid cycle
    {4'd10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001}, // R10 release at cycle end
    {4'd2,  2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b001}, // R2 still requesting as slave
    {4'd3,  2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'b001}, // R3 hold bit alone
    {4'd3,  2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b001}, // R3 wait
    {4'd7,  2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b010}, // R7 owner with no core need
    {4'd8,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b101}, // R8 parked, grant removed
    {4'd4,  2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101}, // R4 wait
    {4'd6,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b101}, // R6 grant lost while waiting
    {4'd4,  2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101}, // R4 wait
    {4'd7,  2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b110}, // R7 parked take-over
    {4'd11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010}, // R11 active
    {4'd9,  2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010}, // R9 more cycles, stays owner
    {4'd10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001}  // R10 split operation
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic er, input logic eo, input logic eb);
    check(tag, "bus_req_n", bus_req_n, er);
    check(tag, "bus_owned", bus_owned, eo);
    check(tag, "bus_busy_out_n", bus_busy_out_n, eb);
  endtask

  task automatic drive(input logic [1:0] e, input logic h, input logic g, input logic b, input logic d);
    core_ext_req = e; req_hold = h; bus_grant_n = g; bus_busy_in_n = b; cycle_done = d;
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1", 1'b1, 1'b0, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      @(negedge clk);
      check_all($sformatf("R%0d row%0d", VEC[i][13:10], i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset while owner returns to idle
    drive(2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R4", "bus_owned before reset", bus_owned, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_all("R1 reset while owner", 1'b1, 1'b0, 1'b1);
    rst = 1'b0;
    drive(2'b00, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R1 slave after reset", 1'b1, 1'b0, 1'b1);

    // R5: long busy stretch keeps waiting
    drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R5", "bus_owned during busy", bus_owned, 1'b0);
    end
    drive(2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R4 owned after busy free", 1'b0, 1'b1, 1'b0);

    // R9: grant removed for many clocks without cycle end
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9", "bus_owned held", bus_owned, 1'b1);
    end
    drive(2'b10, 1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check_all("R10 late release", 1'b0, 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule